// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sets the power state of a small processor core. While the core runs, a power-save command with a mode code puts the core in one of two low-power states. In sleep, the core clock, the peripheral clock, the system oscillator and the clock monitor are all switched off. In idle, only the core clock stops. The low-power watchdog oscillator stays on in sleep only when the watchdog is enabled. When the watchdog is on, the watchdog counter is cleared as sleep begins.

Either low-power state ends on the clock edge after a wake condition appears. A wake condition is any interrupt request whose own enable bit is set, or a watchdog time-out. The controller then raises a one-cycle wake flag. A clock-source selection is captured when a low-power state is entered and held until wake, so the core restarts on the source it left with. Reset is asynchronous and overrides everything else.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `rst_n` is low, the controller is in run. In run, all five enables are high, `wake` is 0 and `clk_src` is 0. A wake condition in the same cycle as reset does not produce a `wake` pulse.
- R2: In run, `save_req` with `save_mode` = 2'b01 (sleep) makes `cpu_clk_en`, `periph_clk_en`, `sysosc_en` and `fscm_en` low from the next clock edge.
- R3: In run, `save_req` with `save_mode` = 2'b10 (idle) makes `cpu_clk_en` low from the next edge. `periph_clk_en`, `sysosc_en` and `fscm_en` stay high.
- R4: In sleep, `lprc_en` equals `wdt_on`. In run and idle, `lprc_en` is 1.
- R5: `wdt_clr` is high for exactly the first cycle of sleep, and only if `wdt_on` was high when the sleep command was accepted. It is never high in run or idle.
- R6: In sleep or idle, a nonzero `irq_req & irq_en` or a high `wdt_timeout` returns the controller to run at the next edge. `wake` is then high for that first run cycle only.
- R7: An interrupt request whose enable bit is 0 does not end sleep or idle.
- R8: A `save_req` made in sleep or idle is ignored. A `save_req` in run with mode code 2'b00 or 2'b11 leaves the controller in run.
- R9: In run, `clk_src` takes the value of `clk_sel` at each edge. The value captured on the edge that enters sleep or idle is held, whatever `clk_sel` does, until the first run cycle after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Power-save command strobe |
| save_mode | input | 2 | Mode code: 01 sleep, 10 idle |
| irq_req | input | IRQ_W | Interrupt requests |
| irq_en | input | IRQ_W | Per-interrupt enables |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_on | input | 1 | Watchdog enabled configuration |
| clk_sel | input | SEL_W | Active clock-source selection |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| sysosc_en | output | 1 | System oscillator enable |
| lprc_en | output | 1 | Watchdog oscillator enable |
| fscm_en | output | 1 | Clock monitor enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| wake | output | 1 | Wake event flag |
| clk_src | output | SEL_W | Held clock-source selection |

## Verification
The assertions check on every cycle:
- the sleep gating of the clocks, oscillator and monitor;
- that the watchdog oscillator follows the watchdog-enable bit in sleep;
- that the clear pulse appears only on sleep entry;
- that the wake flag appears only on a return to run;
- that a low-power state persists without a wake condition;
- that the held clock source does not move after entry.

Only the bench scenarios show the following:
- idle leaves the peripheral clock on;
- disabled interrupts are ignored;
- unknown mode codes are ignored;
- the restored source equals the one captured before sleep;
- reset overrides a wake event that arrives with it.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int IRQ_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic [1:0]       save_mode,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             wdt_timeout,
  input  logic             wdt_on,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             sysosc_en,
  output logic             lprc_en,
  output logic             fscm_en,
  output logic             wdt_clr,
  output logic             wake,
  output logic [SEL_W-1:0] clk_src
);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_IDLE = 2'd1, ST_SLEEP = 2'd2} pstate_t;

  localparam logic [1:0] CODE_SLEEP = 2'b01;
  localparam logic [1:0] CODE_IDLE  = 2'b10;

  pstate_t state, state_nx;
  logic    wake_cond;
  logic    low_pwr;
  logic    go_sleep;

  assign wake_cond = (|(irq_req & irq_en)) | wdt_timeout;
  assign low_pwr   = (state != ST_RUN);
  assign go_sleep  = (state == ST_RUN) && save_req && (save_mode == CODE_SLEEP);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:
        if (save_req) begin
          if (save_mode == CODE_SLEEP)     state_nx = ST_SLEEP;
          else if (save_mode == CODE_IDLE) state_nx = ST_IDLE;
        end
      ST_IDLE, ST_SLEEP:
        if (wake_cond) state_nx = ST_RUN;
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      wdt_clr <= 1'b0;
      wake    <= 1'b0;
      clk_src <= '0;
    end else begin
      state   <= state_nx;
      wdt_clr <= go_sleep && wdt_on;
      wake    <= low_pwr && wake_cond;
      if (!low_pwr) clk_src <= clk_sel;
    end
  end

  assign cpu_clk_en    = !low_pwr;
  assign periph_clk_en = (state != ST_SLEEP);
  assign sysosc_en     = (state != ST_SLEEP);
  assign fscm_en       = (state != ST_SLEEP);
  assign lprc_en       = (state != ST_SLEEP) || wdt_on;

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int IRQ_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IRQ_W-1:0] irq_req,
  input logic [IRQ_W-1:0] irq_en,
  input logic             wdt_timeout,
  input logic             wdt_on,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             sysosc_en,
  input logic             lprc_en,
  input logic             fscm_en,
  input logic             wdt_clr,
  input logic             wake,
  input logic [SEL_W-1:0] clk_src
);

  logic any_wake;
  assign any_wake = (|(irq_req & irq_en)) | wdt_timeout;

  assert_sleep_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> (!cpu_clk_en && !sysosc_en && !fscm_en));

  assert_lprc_follows_wdt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> (lprc_en == wdt_on));

  assert_clr_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> (!periph_clk_en && $past(periph_clk_en) && $past(cpu_clk_en)));

  assert_wake_on_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (cpu_clk_en && !$past(cpu_clk_en)));

  assert_stay_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !any_wake) |=> (!cpu_clk_en && $stable(periph_clk_en)));

  assert_src_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cpu_clk_en) |-> $stable(clk_src));

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.IRQ_W(IRQ_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  localparam int IW = 4;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 1'b0;
  logic [1:0] save_mode = 2'b00;
  logic [IW-1:0] irq_req = '0, irq_en = '0;
  logic wdt_timeout = 1'b0, wdt_on = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic cpu_clk_en, periph_clk_en, sysosc_en, lprc_en, fscm_en, wdt_clr, wake;
  logic [2:0] clk_src;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwr_mode_ctl #(.IRQ_W(IW), .SEL_W(3)) u_dut (.*);

  // inputs: {save, mode[1:0], req[3:0], en[3:0], wdt_to, wdt_on, sel[2:0]}
  localparam logic [15:0] VIN [NV] = '{
    {1'b0, 2'b00, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd5},
    {1'b1, 2'b01, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd5},
    {1'b0, 2'b00, 4'b0001, 4'b0000, 1'b0, 1'b1, 3'd2},
    {1'b1, 2'b10, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd2},
    {1'b0, 2'b00, 4'b0100, 4'b0100, 1'b0, 1'b1, 3'd2},
    {1'b0, 2'b00, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd2},
    {1'b1, 2'b10, 4'b0000, 4'b0000, 1'b0, 1'b0, 3'd2},
    {1'b0, 2'b00, 4'b0000, 4'b0000, 1'b1, 1'b0, 3'd2},
    {1'b1, 2'b01, 4'b0000, 4'b0000, 1'b0, 1'b0, 3'd3},
    {1'b0, 2'b00, 4'b0000, 4'b0000, 1'b1, 1'b0, 3'd3},
    {1'b1, 2'b11, 4'b0000, 4'b0000, 1'b0, 1'b0, 3'd3},
    {1'b1, 2'b10, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd6},
    {1'b0, 2'b00, 4'b1000, 4'b0111, 1'b0, 1'b1, 3'd1},
    {1'b1, 2'b01, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd1},
    {1'b0, 2'b00, 4'b1000, 4'b1000, 1'b0, 1'b1, 3'd1}
  };
  // expected: {cpu, periph, sysosc, lprc, fscm, wdt_clr, wake, src[2:0]}
  localparam logic [9:0] VEXP [NV] = '{
    {7'b1111100, 3'd5},
    {7'b0001010, 3'd5},
    {7'b0001000, 3'd5},
    {7'b0001000, 3'd5},
    {7'b1111101, 3'd5},
    {7'b1111100, 3'd2},
    {7'b0111100, 3'd2},
    {7'b1111101, 3'd2},
    {7'b0000000, 3'd3},
    {7'b1111101, 3'd3},
    {7'b1111100, 3'd3},
    {7'b0111100, 3'd6},
    {7'b0111100, 3'd6},
    {7'b0111100, 3'd6},
    {7'b1111101, 3'd6}
  };
  localparam string VTAG [NV] = '{"R9", "R5", "R7", "R8", "R6", "R9", "R3", "R6",
                                  "R4", "R6", "R8", "R3", "R7", "R8", "R6"};

  function automatic logic [9:0] outs();
    return {cpu_clk_en, periph_clk_en, sysosc_en, lprc_en, fscm_en, wdt_clr, wake, clk_src};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", outs(), {7'b1111100, 3'd0});
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {save_req, save_mode, irq_req, irq_en, wdt_timeout, wdt_on, clk_sel} = VIN[i];
      @(negedge clk);
      check(VTAG[i], outs(), VEXP[i]);
    end
    {save_req, save_mode, irq_req, irq_en, wdt_timeout, wdt_on, clk_sel} = '0;
    @(negedge clk);
    check("R6", {9'b0, wake}, 10'd0);

    // R2: sleep entry gates the clocks, oscillator and monitor
    save_req = 1'b1; save_mode = 2'b01; wdt_on = 1'b1; clk_sel = 3'd7;
    @(negedge clk);
    save_req = 1'b0;
    check("R2", outs(), {7'b0001010, 3'd7});
    @(negedge clk);
    check("R5", {9'b0, wdt_clr}, 10'd0);

    // R1: reset arriving together with a wake condition
    irq_req = 4'b0010; irq_en = 4'b0010; rst_n = 1'b0;
    @(negedge clk);
    check("R1", outs(), {7'b1111100, 3'd0});
    irq_req = '0; irq_en = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {9'b0, wake}, 10'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule